// File: doc/BRIEF.md
# Debug Trace Message Output Port

This block collects debug trace messages from up to four on-chip trace sources and sends them out, one beat per clock, on a narrow auxiliary port to an external debug tool. Each message holds a 6-bit transfer code, a 4-bit source processor number and a payload. The payload length depends on the transfer code, so only the bits that carry information are sent. The message leaves the port least significant bit first.

When several sources request in the same cycle, a fixed-priority arbiter picks one. The accepted message goes into an eight-entry queue that sits in front of the serializer. The port is either 8 or 2 bits wide, selected at run time. A 2-bit sideband marks the first beat, the middle beats, the last beat and idle cycles. If a message arrives while the queue is full, it is discarded. A single overflow message is then queued as soon as a slot frees up.

A message enable turns the whole path off. While it is low, no source is accepted, the queue is emptied and the port goes idle. The enable may already be high while reset is asserted, so that activity right after reset can be traced.

Top module: `dbg_msg_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, portFrame is 2'b11, portData is zero and no srcGrant bit is set.
- R2: A message is the bit string {payload, procId, transfer code}: transfer code in bits 5:0, procId in bits 9:6, payload from bit 10 upward. Beat k carries message bits k*W to k*W+W-1, where W is the port width.
- R3: The payload length in bits depends on the transfer code: 2 gives 32, 3 gives 8, 4 gives 40, 5 and 6 give 48, 8 gives 0, 15 gives 4, and any other code gives 32. A message therefore takes ceil((10+length)/W) beats.
- R4: With portWide=1, W is 8. With portWide=0, W is 2: the message is on portData[1:0] and portData[7:2] is zero. The width is sampled when a message starts, and a change during the message has no effect on it.
- R5: The framing codes are 2'b00 for the first beat, 2'b10 for a middle beat, 2'b01 for the last beat and 2'b11 for idle. Every message has a first beat and a last beat.
- R6: Payload bits above the message's length are sent as zero. portData is zero on idle beats.
- R7: At most one srcGrant bit is set per cycle. It goes to the lowest-numbered valid source: 0 is program trace, 1 is data trace, 2 is watchpoint and 3 is ownership. A grant means the message was taken in that cycle.
- R8: The queue holds 8 messages. A message granted while the queue is full is discarded. One overflow message, with transfer code 8 and no payload, is then queued at the first free slot, ahead of any new source message.
- R9: While msgEnable is low, no source is granted. From the next cycle the port is idle, and queued or partly sent messages are discarded.
- R10: With msgEnable high during reset, a request made in the first cycle after reset is granted and sent.
- R11: When the port and the queue are idle, a message granted in cycle N shows its first beat in cycle N+2. A queued message starts in the cycle right after the previous message's last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| msgEnable | input | 1 | Turns the message path on |
| portWide | input | 1 | 1 selects the 8-bit port, 0 the 2-bit port |
| procId | input | 4 | Source processor number placed in every message |
| srcValid | input | 4 | A request from each trace source |
| srcTcode | input | 24 | Transfer code of each source, 6 bits per source |
| srcPayload | input | 192 | Payload of each source, 48 bits per source |
| srcGrant | output | 4 | The source whose message is taken this cycle |
| portData | output | 8 | Message beat |
| portFrame | output | 2 | Start, middle, end and idle framing |

## Verification
srcGrant is combinational, so the bench reads it 1 ns after it drives the requests. The bench drives and samples on the falling clock edge.

A message granted at one rising edge goes into the queue at that edge. It is loaded into the serializer at the next edge, so its first beat is sampled two falling edges after the request.

Later beats follow one per cycle. The bench checks that the next queued message begins at the first falling edge after the previous last beat. After msgEnable drops, the port is checked one cycle later.

// File: rtl/dbg_msg_pkg.sv
package dbg_msg_pkg;

  localparam int TCODE_W  = 6;
  localparam int SRC_W    = 4;
  localparam int PAY_W    = 48;
  localparam int MSG_W    = TCODE_W + SRC_W + PAY_W;
  localparam int WIDE_W   = 8;
  localparam int NARROW_W = 2;
  localparam int BEAT_W   = $clog2(MSG_W / NARROW_W + 2);

  localparam logic [TCODE_W-1:0] TC_OWNER    = 6'd2;
  localparam logic [TCODE_W-1:0] TC_PROG_DIR = 6'd3;
  localparam logic [TCODE_W-1:0] TC_PROG_IND = 6'd4;
  localparam logic [TCODE_W-1:0] TC_DATA_WR  = 6'd5;
  localparam logic [TCODE_W-1:0] TC_DATA_RD  = 6'd6;
  localparam logic [TCODE_W-1:0] TC_OVERFLOW = 6'd8;
  localparam logic [TCODE_W-1:0] TC_WATCH    = 6'd15;

  typedef enum logic [1:0] {
    FR_FIRST  = 2'b00,
    FR_LAST   = 2'b01,
    FR_MIDDLE = 2'b10,
    FR_IDLE   = 2'b11
  } frame_e;

  typedef struct packed {
    logic [TCODE_W-1:0] tcode;
    logic [PAY_W-1:0]   payload;
  } entry_t;

  typedef struct packed {
    logic push;
    logic pushOvf;
    logic load;
    logic shift;
  } strobe_t;

  function automatic int payBits(input logic [TCODE_W-1:0] tc);
    case (tc)
      TC_OWNER:               return 32;
      TC_PROG_DIR:            return 8;
      TC_PROG_IND:            return 40;
      TC_DATA_WR, TC_DATA_RD: return 48;
      TC_OVERFLOW:            return 0;
      TC_WATCH:               return 4;
      default:                return 32;
    endcase
  endfunction

  function automatic logic [PAY_W-1:0] payMask(input logic [TCODE_W-1:0] tc);
    return ~({PAY_W{1'b1}} << payBits(tc));
  endfunction

  function automatic logic [BEAT_W-1:0] beatsFor(input logic [TCODE_W-1:0] tc,
                                                 input logic wide);
    int bits;
    bits = TCODE_W + SRC_W + payBits(tc);
    if (wide) return BEAT_W'((bits + WIDE_W - 1) / WIDE_W);
    return BEAT_W'((bits + NARROW_W - 1) / NARROW_W);
  endfunction

endpackage

// File: rtl/dbg_msg_ctrl.sv
module dbg_msg_ctrl
  import dbg_msg_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int NUM_SRC = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               msgEnable,
  input  logic               portWide,
  input  logic [NUM_SRC-1:0] srcValid,
  input  logic [TCODE_W-1:0] headTcode,
  output logic [NUM_SRC-1:0] srcGrant,
  output logic [IW-1:0]      winIdx,
  output logic [AW-1:0]      wrPtr,
  output logic [AW-1:0]      rdPtr,
  output strobe_t            strb,
  output logic               outBusy,
  output logic               outWide,
  output logic [1:0]         portFrame
);

  logic [CW-1:0]     count;
  logic              lostFlag;
  logic              first;
  logic [BEAT_W-1:0] beatsLeft;
  logic              anyReq, full, empty, lastBeat, pushAny, dropNow;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign lastBeat = outBusy && (beatsLeft == BEAT_W'(1));
  assign anyReq   = |srcValid;

  // fixed priority: the lowest index wins
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (srcValid[i]) winIdx = IW'(i);
    end
  end

  always_comb begin
    strb     = '0;
    srcGrant = '0;
    dropNow  = 1'b0;
    if (msgEnable) begin
      strb.load  = !empty && (!outBusy || lastBeat);
      strb.shift = outBusy;
      if (lostFlag && !full) begin
        strb.pushOvf = 1'b1;
      end else if (anyReq) begin
        srcGrant[winIdx] = 1'b1;
        strb.push        = !full;
        dropNow          = full;
      end
    end
  end

  assign pushAny = strb.push || strb.pushOvf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      lostFlag  <= 1'b0;
      outBusy   <= 1'b0;
      first     <= 1'b0;
      outWide   <= 1'b0;
      beatsLeft <= '0;
    end else if (!msgEnable) begin
      count    <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      lostFlag <= 1'b0;
      outBusy  <= 1'b0;
      first    <= 1'b0;
    end else begin
      if (pushAny) wrPtr <= bump(wrPtr);
      if (strb.load) rdPtr <= bump(rdPtr);
      if (pushAny && !strb.load) count <= count + 1'b1;
      else if (!pushAny && strb.load) count <= count - 1'b1;

      if (strb.pushOvf) lostFlag <= 1'b0;
      else if (dropNow) lostFlag <= 1'b1;

      if (strb.load) begin
        outBusy   <= 1'b1;
        first     <= 1'b1;
        outWide   <= portWide;
        beatsLeft <= beatsFor(headTcode, portWide);
      end else if (outBusy) begin
        first     <= 1'b0;
        beatsLeft <= beatsLeft - 1'b1;
        if (lastBeat) outBusy <= 1'b0;
      end
    end
  end

  always_comb begin
    if (!outBusy)                        portFrame = FR_IDLE;
    else if (first)                      portFrame = FR_FIRST;
    else if (beatsLeft == BEAT_W'(1))    portFrame = FR_LAST;
    else                                 portFrame = FR_MIDDLE;
  end

endmodule

// File: rtl/dbg_msg_dp.sv
module dbg_msg_dp
  import dbg_msg_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int NUM_SRC = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                       clk,
  input  strobe_t                    strb,
  input  logic [IW-1:0]              winIdx,
  input  logic [AW-1:0]              wrPtr,
  input  logic [AW-1:0]              rdPtr,
  input  logic [SRC_W-1:0]           procId,
  input  logic [NUM_SRC*TCODE_W-1:0] srcTcode,
  input  logic [NUM_SRC*PAY_W-1:0]   srcPayload,
  input  logic                       outBusy,
  input  logic                       outWide,
  output logic [TCODE_W-1:0]         headTcode,
  output logic [WIDE_W-1:0]          portData
);

  logic [TCODE_W-1:0] tcOf  [NUM_SRC];
  logic [PAY_W-1:0]   payOf [NUM_SRC];
  entry_t             mem   [DEPTH];
  entry_t             head;
  logic [MSG_W-1:0]   sr;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign tcOf[g]  = srcTcode[g*TCODE_W +: TCODE_W];
    assign payOf[g] = srcPayload[g*PAY_W +: PAY_W];
  end

  assign head      = mem[rdPtr];
  assign headTcode = head.tcode;

  always_ff @(posedge clk) begin
    if (strb.push)
      mem[wrPtr] <= '{tcode: tcOf[winIdx], payload: payOf[winIdx]};
    else if (strb.pushOvf)
      mem[wrPtr] <= '{tcode: TC_OVERFLOW, payload: '0};

    if (strb.load)
      sr <= {head.payload & payMask(head.tcode), procId, head.tcode};
    else if (strb.shift)
      sr <= outWide ? (sr >> WIDE_W) : (sr >> NARROW_W);
  end

  always_comb begin
    if (!outBusy)     portData = '0;
    else if (outWide) portData = sr[WIDE_W-1:0];
    else              portData = WIDE_W'(sr[NARROW_W-1:0]);
  end

endmodule

// File: rtl/dbg_msg_port.sv
module dbg_msg_port
  import dbg_msg_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int NUM_SRC = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       msgEnable,
  input  logic                       portWide,
  input  logic [SRC_W-1:0]           procId,
  input  logic [NUM_SRC-1:0]         srcValid,
  input  logic [NUM_SRC*TCODE_W-1:0] srcTcode,
  input  logic [NUM_SRC*PAY_W-1:0]   srcPayload,
  output logic [NUM_SRC-1:0]         srcGrant,
  output logic [WIDE_W-1:0]          portData,
  output logic [1:0]                 portFrame
);

  localparam int AW = $clog2(DEPTH);
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  strobe_t            strb;
  logic [IW-1:0]      winIdx;
  logic [AW-1:0]      wrPtr, rdPtr;
  logic [TCODE_W-1:0] headTcode;
  logic               outBusy, outWide;

  dbg_msg_ctrl #(.DEPTH(DEPTH), .NUM_SRC(NUM_SRC)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .msgEnable (msgEnable),
    .portWide  (portWide),
    .srcValid  (srcValid),
    .headTcode (headTcode),
    .srcGrant  (srcGrant),
    .winIdx    (winIdx),
    .wrPtr     (wrPtr),
    .rdPtr     (rdPtr),
    .strb      (strb),
    .outBusy   (outBusy),
    .outWide   (outWide),
    .portFrame (portFrame)
  );

  dbg_msg_dp #(.DEPTH(DEPTH), .NUM_SRC(NUM_SRC)) u_dp (
    .clk        (clk),
    .strb       (strb),
    .winIdx     (winIdx),
    .wrPtr      (wrPtr),
    .rdPtr      (rdPtr),
    .procId     (procId),
    .srcTcode   (srcTcode),
    .srcPayload (srcPayload),
    .outBusy    (outBusy),
    .outWide    (outWide),
    .headTcode  (headTcode),
    .portData   (portData)
  );

endmodule

// File: rtl/dbg_msg_port_chk.sv
module dbg_msg_port_chk
  import dbg_msg_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               msgEnable,
  input logic [NUM_SRC-1:0] srcValid,
  input logic [NUM_SRC-1:0] srcGrant,
  input logic [WIDE_W-1:0]  portData,
  input logic [1:0]         portFrame
);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcGrant)); // R7

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (srcGrant & ~srcValid) == '0); // R7

  AST_PROG_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (srcValid[0] && (srcGrant != '0)) |-> srcGrant[0]); // R7

  AST_OFF_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    !msgEnable |-> (srcGrant == '0)); // R9

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !msgEnable |=> (portFrame == FR_IDLE && portData == '0)); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (portFrame == FR_IDLE) |-> (portData == '0)); // R6

  AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (portFrame == FR_IDLE) |=> (portFrame == FR_IDLE || portFrame == FR_FIRST)); // R5

  AST_FIRST_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (msgEnable && portFrame == FR_FIRST) |=>
      (portFrame == FR_MIDDLE || portFrame == FR_LAST)); // R5

  AST_MIDDLE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (msgEnable && portFrame == FR_MIDDLE) |=>
      (portFrame == FR_MIDDLE || portFrame == FR_LAST)); // R5

endmodule

bind dbg_msg_port dbg_msg_port_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .msgEnable (msgEnable),
  .srcValid  (srcValid),
  .srcGrant  (srcGrant),
  .portData  (portData),
  .portFrame (portFrame)
);

// File: tb/dbg_msg_port_tb.sv
module dbg_msg_port_tb;
  import dbg_msg_pkg::*;

  localparam int NS = 4;
  localparam logic [3:0] PROC = 4'hA;

  typedef struct packed {
    logic [1:0]  src;
    logic [5:0]  tc;
    logic [47:0] pay;
    logic        wide;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 6'd3,  48'hFFFF_FFFF_FFA5, 1'b0},
    '{2'd0, 6'd4,  48'hABCD_1234_5678, 1'b1},
    '{2'd1, 6'd5,  48'h0123_4567_89AB, 1'b0},
    '{2'd1, 6'd6,  48'hFEDC_BA98_7654, 1'b1},
    '{2'd2, 6'd15, 48'h0000_0000_0009, 1'b1},
    '{2'd3, 6'd2,  48'h0000_DEAD_BEEF, 1'b0},
    '{2'd2, 6'd15, 48'hFFFF_FFFF_FFF3, 1'b0},
    '{2'd3, 6'd33, 48'hFFFF_0F0F_0F0F, 1'b1}
  };

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           msgEnable = 1'b1;
  logic           portWide = 1'b0;
  logic [3:0]     procId = PROC;
  logic [NS-1:0]  srcValid = '0;
  logic [NS*6-1:0]  srcTcode = '0;
  logic [NS*48-1:0] srcPayload = '0;
  logic [NS-1:0]  srcGrant;
  logic [7:0]     portData;
  logic [1:0]     portFrame;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dbg_msg_port u_dut (
    .clk(clk), .rstN(rstN), .msgEnable(msgEnable), .portWide(portWide),
    .procId(procId), .srcValid(srcValid), .srcTcode(srcTcode),
    .srcPayload(srcPayload), .srcGrant(srcGrant), .portData(portData),
    .portFrame(portFrame)
  );

  // payload lengths as listed in R3
  function automatic int expPay(input logic [5:0] tc);
    case (tc)
      6'd2: return 32;
      6'd3: return 8;
      6'd4: return 40;
      6'd5, 6'd6: return 48;
      6'd8: return 0;
      6'd15: return 4;
      default: return 32;
    endcase
  endfunction

  function automatic logic [63:0] expMsg(input logic [5:0] tc, input logic [47:0] pay);
    int pb;
    logic [47:0] m;
    pb = expPay(tc);
    m = (pb >= 48) ? '1 : ((48'd1 << pb) - 48'd1);
    return 64'({pay & m, PROC, tc});
  endfunction

  function automatic int expBeats(input logic [5:0] tc, input bit wide);
    int bits;
    bits = 10 + expPay(tc);
    return wide ? (bits + 7) / 8 : (bits + 1) / 2;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic setSrc(input int s, input logic [5:0] tc, input logic [47:0] pay);
    srcTcode[s*6 +: 6]     = tc;
    srcPayload[s*48 +: 48] = pay;
  endtask

  task automatic collect(input bit wide, output logic [63:0] acc, output int beats,
                         output int gap, output bit upperBad, output bit frameBad);
    int pos;
    acc = '0; beats = 0; gap = 0; upperBad = 0; frameBad = 0; pos = 0;
    @(negedge clk);
    while (portFrame != 2'b00 && gap < 400) begin
      gap++;
      @(negedge clk);
    end
    if (gap >= 400) begin
      frameBad = 1;
      return;
    end
    forever begin
      beats++;
      if (wide) acc |= 64'(portData) << pos;
      else begin
        acc |= 64'(portData[1:0]) << pos;
        if (portData[7:2] != 6'd0) upperBad = 1;
      end
      pos += wide ? 8 : 2;
      if (portFrame == 2'b01) break;
      if (beats > 1 && portFrame != 2'b10) begin frameBad = 1; break; end
      if (beats > 40) begin frameBad = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic expectMsg(input bit wide, input logic [5:0] tc, input logic [47:0] pay,
                           input string tag, input int maxGap);
    logic [63:0] acc;
    int beats, gap;
    bit upperBad, frameBad;
    collect(wide, acc, beats, gap, upperBad, frameBad);
    check(!frameBad, {tag, " framing R5"}, 64'(frameBad), 64'd0);
    check(acc == expMsg(tc, pay), {tag, " content R2 R6"}, acc, expMsg(tc, pay));
    check(beats == expBeats(tc, wide), {tag, " beat count R3 R4"},
          64'(beats), 64'(expBeats(tc, wide)));
    if (!wide) check(!upperBad, {tag, " narrow upper bits R4"}, 64'(upperBad), 64'd0);
    if (maxGap >= 0) check(gap <= maxGap, {tag, " start latency R11"}, 64'(gap), 64'(maxGap));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(portFrame == 2'b11 && portData == 8'd0 && srcGrant == '0, "R1 in reset",
          {54'd0, portFrame, portData}, {54'd0, 2'b11, 8'd0});
    rstN = 1'b1;
    @(negedge clk);
    check(portFrame == 2'b11 && portData == 8'd0 && srcGrant == '0, "R1 after reset",
          {54'd0, portFrame, portData}, {54'd0, 2'b11, 8'd0});

    // table of single messages: R2 R3 R4 R6 R7 R11
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      portWide = VECS[i].wide;
      setSrc(int'(VECS[i].src), VECS[i].tc, VECS[i].pay);
      srcValid[VECS[i].src] = 1'b1;
      #1;
      check(srcGrant == NS'(1 << VECS[i].src), "R7 single request grant",
            64'(srcGrant), 64'(1 << VECS[i].src));
      @(negedge clk);
      srcValid = '0;
      expectMsg(VECS[i].wide, VECS[i].tc, VECS[i].pay, "table", 0);
    end

    // R7 priority order and R11 back-to-back
    portWide = 1'b1;
    setSrc(0, 6'd3, 48'h0000_0000_0011);
    setSrc(1, 6'd5, 48'h1111_2222_3333);
    setSrc(2, 6'd15, 48'h0000_0000_0006);
    setSrc(3, 6'd2, 48'h0000_CAFE_F00D);
    fork
      begin
        @(negedge clk);
        srcValid = 4'hF;
        for (int k = 0; k < 4; k++) begin
          #1;
          check(srcGrant == NS'(1 << k), "R7 priority order", 64'(srcGrant), 64'(1 << k));
          @(negedge clk);
          srcValid[k] = 1'b0;
        end
      end
      begin
        expectMsg(1'b1, 6'd3, 48'h0000_0000_0011, "prio program", -1);
        expectMsg(1'b1, 6'd5, 48'h1111_2222_3333, "prio data", 0);
        expectMsg(1'b1, 6'd15, 48'h0000_0000_0006, "prio watch", 0);
        expectMsg(1'b1, 6'd2, 48'h0000_CAFE_F00D, "prio owner", 0);
      end
    join

    // R8: queue overflow
    portWide = 1'b0;
    fork
      begin
        @(negedge clk);
        for (int k = 0; k < 11; k++) begin
          setSrc(1, 6'd5, 48'(k) + 48'h100);
          srcValid[1] = 1'b1;
          #1;
          check(srcGrant == 4'b0010, "R8 taken even when full", 64'(srcGrant), 64'd2);
          @(negedge clk);
        end
        srcValid = '0;
      end
      begin
        for (int k = 0; k < 9; k++) expectMsg(1'b0, 6'd5, 48'(k) + 48'h100, "R8 kept", -1);
        expectMsg(1'b0, 6'd8, 48'd0, "R8 overflow marker", 0);
      end
    join
    begin
      bit extra;
      extra = 0;
      repeat (40) begin
        @(negedge clk);
        if (portFrame != 2'b11) extra = 1;
      end
      check(!extra, "R8 dropped messages not sent", 64'(extra), 64'd0);
    end

    // R4: width change during a message is ignored
    portWide = 1'b0;
    setSrc(3, 6'd2, 48'h0000_1357_9BDF);
    fork
      begin
        @(negedge clk);
        srcValid[3] = 1'b1;
        @(negedge clk);
        srcValid = '0;
        repeat (5) @(negedge clk);
        portWide = 1'b1;
      end
      expectMsg(1'b0, 6'd2, 48'h0000_1357_9BDF, "R4 width held", -1);
    join

    // R9: disable drops everything, R11 first beat two cycles after grant
    portWide = 1'b0;
    setSrc(0, 6'd4, 48'h00AA_BBCC_DDEE);
    setSrc(2, 6'd15, 48'h0000_0000_0003);
    @(negedge clk);
    srcValid = 4'b0101;
    #1 check(srcGrant == 4'b0001, "R7 program before watchpoint", 64'(srcGrant), 64'd1);
    @(negedge clk);
    srcValid[0] = 1'b0;
    #1 check(srcGrant == 4'b0100, "R7 watchpoint next", 64'(srcGrant), 64'd4);
    @(negedge clk);
    srcValid[2] = 1'b0;
    check(portFrame == 2'b00, "R11 first beat at N+2", 64'(portFrame), 64'd0);
    @(negedge clk);
    msgEnable = 1'b0;
    setSrc(3, 6'd2, 48'h1);
    srcValid[3] = 1'b1;
    #1 check(srcGrant == '0, "R9 no grant while off", 64'(srcGrant), 64'd0);
    @(negedge clk);
    check(portFrame == 2'b11 && portData == 8'd0, "R9 idle after disable",
          {54'd0, portFrame, portData}, {54'd0, 2'b11, 8'd0});
    srcValid = '0;
    msgEnable = 1'b1;
    begin
      bit leftover;
      leftover = 0;
      repeat (40) begin
        @(negedge clk);
        if (portFrame != 2'b11) leftover = 1;
      end
      check(!leftover, "R9 queue emptied", 64'(leftover), 64'd0);
    end

    // R10: enabled through reset, request in the first cycle after release
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    portWide = 1'b1;
    setSrc(2, 6'd15, 48'h5);
    srcValid[2] = 1'b1;
    #1 check(srcGrant == 4'b0100, "R10 grant right after reset", 64'(srcGrant), 64'd4);
    @(negedge clk);
    srcValid = '0;
    expectMsg(1'b1, 6'd15, 48'h5, "R10 traced from reset", 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule